// File: doc/BRIEF.md
# Manchester Gate Word Receiver

This block takes a single serial line that carries power-stage gate commands and turns it back into a parallel gate word. The sender and receiver do not share a clock. The receiver samples the line with its own clock, several samples per half-cell, and aligns its sampling phase to the edges of the Manchester-coded data. A frame starts with a deliberate code violation: a run of high half-cells followed by a run of low half-cells, each longer than any legal Manchester run. The data bits come straight after it. Each bit is decoded from its two half-cells and placed in the word.

The gate outputs are only released once the link has proven itself. A short filter counts good and bad frames and sets a lock flag. While the flag is clear, every gate output is held low so that all switches stay off. Frames with a broken bit are dropped in full. The outputs then keep the previous good word.

The parallel side is a valid-only stream. `frame_valid` marks the one cycle in which a new word is applied to `gate`. A serial line cannot be paused, so there is no ready input and no back-pressure. A consumer that needs the word must take it on the strobe, or read the steady `gate` level afterwards.

Top module: `mrx_gate_rx`

## Requirements
- R1: The line input passes through a two-flop synchronizer. It is sampled OSR (default 8) times per half-cell. The sampling phase restarts on every transition, so a sender half-cell of OSR+1 samples is still decoded correctly.
- R2: A data bit of value 1 is a high half-cell followed by a low one. A value of 0 is low then high. The first data bit after the sync lands on gate[0], and the sixth lands on gate[5].
- R3: A frame boundary is a run of three high half-cells followed by three low half-cells. The half-cell after the third low one is the first half of data bit 0. The boundary is still found when the high run merges with a preceding high data half-cell or a high idle level.
- R4: If the two half-cells of any data bit are equal, the whole frame is discarded. No strobe is raised and the gate outputs keep their previous value.
- R5: While locked, each complete frame with no code error updates all gate bits on one clock edge. `frame_valid` is high for exactly that one cycle. At no other time does a gate bit change, except when it is forced low by R8.
- R6: The lock flag sets after two consecutive good frames. The word of the frame that completes the lock is applied on the same edge that sets the flag.
- R7: The lock flag clears after two consecutive bad frames. A bad frame is either a code error or 18 half-cell periods without a sync after the previous frame ended. A single good frame restarts the bad count.
- R8: During reset and whenever the lock flag is clear, all gate outputs are 0 and `frame_valid` is 0. After reset the lock flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, OSR times the half-cell rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Manchester-coded serial line, asynchronous to clk |
| gate | output | 6 | Recovered gate word, forced to 0 while unlocked |
| frame_valid | output | 1 | One-cycle strobe when a new word is applied to gate |
| locked | output | 1 | Link lock flag |

## Verification
The frame that completes the lock does two jobs at once. It raises `locked` and it applies its own word with the strobe, both on the same edge. The bench provokes this after reset by sending two good frames. It then checks that no strobe was ever seen while the flag was low, and that the word present on the strobe is the second frame's word rather than zero. A second coincidence occurs when a frame with a code error arrives while the link is locked. The discard and the first step toward unlock happen together. The bench judges this by checking that the gate word is unchanged, that no strobe was raised, and that `locked` stays high until a second bad frame arrives.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_DATA = 1'b1
  } mrx_state_e;

  // three high half-cells then three low half-cells, oldest on the left
  localparam logic [5:0] SYNC_PAT = 6'b111000;
  localparam int SYNC_LEN = 6;
endpackage

// File: rtl/mrx_line_sync.sv
module mrx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edge_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign lvl    = chain[STAGES-1];
  assign edge_o = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/mrx_phase.sv
module mrx_phase #(
  parameter int OSR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_i,
  output logic tok_o,
  output logic tok_lvl_o
);
  localparam int PW  = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int MID = OSR / 2;

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      tok_o     <= 1'b0;
      tok_lvl_o <= 1'b0;
    end else begin
      if (edge_i)                        phase <= '0;
      else if (phase == PW'(OSR - 1))    phase <= '0;
      else                               phase <= phase + 1'b1;
      tok_o     <= !edge_i && (phase == PW'(MID - 1));
      tok_lvl_o <= lvl;
    end
  end

  AST_TOKEN_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tok_o |=> !tok_o); // R1
endmodule

// File: rtl/mrx_framer.sv
module mrx_framer
  import mrx_pkg::*;
#(
  parameter int NBITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_i,
  input  logic             lvl_i,
  output logic             good_o,
  output logic             bad_o,
  output logic [NBITS-1:0] word_o
);
  localparam int FRAME_TOK = SYNC_LEN + 2 * NBITS;
  localparam int HW        = $clog2(FRAME_TOK);
  localparam int CW        = $clog2(2 * NBITS);

  mrx_state_e       state;
  logic [4:0]       win;
  logic [5:0]       look;
  logic [HW-1:0]    hunt_cnt;
  logic [CW-1:0]    hcnt;
  logic             first;
  logic [NBITS-1:0] sr;

  assign look = {win, lvl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HUNT;
      win      <= '0;
      hunt_cnt <= '0;
      hcnt     <= '0;
      first    <= 1'b0;
      sr       <= '0;
      good_o   <= 1'b0;
      bad_o    <= 1'b0;
      word_o   <= '0;
    end else begin
      good_o <= 1'b0;
      bad_o  <= 1'b0;
      if (tok_i) begin
        win <= look[4:0];
        case (state)
          ST_HUNT: begin
            if (look == SYNC_PAT) begin
              state    <= ST_DATA;
              hcnt     <= '0;
              hunt_cnt <= '0;
            end else if (hunt_cnt == HW'(FRAME_TOK - 1)) begin
              bad_o    <= 1'b1;
              hunt_cnt <= '0;
            end else begin
              hunt_cnt <= hunt_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (!hcnt[0]) begin
              first <= lvl_i;
              hcnt  <= hcnt + 1'b1;
            end else if (lvl_i == first) begin
              bad_o <= 1'b1;
              state <= ST_HUNT;
            end else begin
              sr <= {first, sr[NBITS-1:1]};
              if (hcnt == CW'(2 * NBITS - 1)) begin
                good_o <= 1'b1;
                word_o <= {first, sr[NBITS-1:1]};
                state  <= ST_HUNT;
              end else begin
                hcnt <= hcnt + 1'b1;
              end
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  AST_EVENT_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (good_o || bad_o) |-> $past(tok_i)); // R4
endmodule

// File: rtl/mrx_lock.sv
module mrx_lock #(
  parameter int NBITS    = 6,
  parameter int LOCK_N   = 2,
  parameter int UNLOCK_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic [NBITS-1:0] word_i,
  output logic [NBITS-1:0] gate_o,
  output logic             strobe_o,
  output logic             locked_o
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(UNLOCK_N + 1);

  logic [GW-1:0] good_run;
  logic [BW-1:0] bad_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_run <= '0;
      bad_run  <= '0;
      locked_o <= 1'b0;
      gate_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (good_i) begin
        bad_run <= '0;
        if (good_run != GW'(LOCK_N)) good_run <= good_run + 1'b1;
        if (locked_o || good_run >= GW'(LOCK_N - 1)) begin
          locked_o <= 1'b1;
          gate_o   <= word_i;
          strobe_o <= 1'b1;
        end
      end else if (bad_i) begin
        good_run <= '0;
        if (bad_run != BW'(UNLOCK_N)) bad_run <= bad_run + 1'b1;
        if (bad_run >= BW'(UNLOCK_N - 1)) begin
          locked_o <= 1'b0;
          gate_o   <= '0;
        end
      end
    end
  end

  AST_GATES_OFF_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_o |-> (gate_o == '0)); // R8
  AST_STROBE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> locked_o); // R5
  AST_GATE_CHANGE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o != $past(gate_o)) |-> (strobe_o || !locked_o)); // R5
  AST_LOCK_RISE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(good_i)); // R6
  AST_LOCK_FALL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(bad_i)); // R7
endmodule

// File: rtl/mrx_gate_rx.sv
module mrx_gate_rx #(
  parameter int OSR      = 8,
  parameter int NBITS    = 6,
  parameter int SYNC_FF  = 2,
  parameter int LOCK_N   = 2,
  parameter int UNLOCK_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [NBITS-1:0] gate,
  output logic             frame_valid,
  output logic             locked
);
  logic             line_lvl, line_edge;
  logic             tok, tok_lvl;
  logic             good, bad;
  logic [NBITS-1:0] word;

  mrx_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .lvl(line_lvl), .edge_o(line_edge)
  );

  mrx_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n), .lvl(line_lvl), .edge_i(line_edge),
    .tok_o(tok), .tok_lvl_o(tok_lvl)
  );

  mrx_framer #(.NBITS(NBITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tok_i(tok), .lvl_i(tok_lvl),
    .good_o(good), .bad_o(bad), .word_o(word)
  );

  mrx_lock #(.NBITS(NBITS), .LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .good_i(good), .bad_i(bad), .word_i(word),
    .gate_o(gate), .strobe_o(frame_valid), .locked_o(locked)
  );
endmodule

// File: tb/tb_mrx_gate_rx.sv
`timescale 1ns/1ps
module tb_mrx_gate_rx;
  localparam int HC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser = 1'b0;
  logic [5:0] gate;
  logic       frame_valid;
  logic       locked;

  int errors = 0;
  int checks = 0;
  int strobes = 0;
  int strobe_unlocked = 0;
  logic [5:0] last_gate = '0;

  always #2.5 clk = ~clk;

  mrx_gate_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser),
    .gate(gate), .frame_valid(frame_valid), .locked(locked)
  );

  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      strobes++;
      last_gate = gate;
      if (!locked) strobe_unlocked++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half(input logic lvl, input int len);
    ser = lvl;
    repeat (len) @(negedge clk);
  endtask

  task automatic hold(input int halves, input int len);
    repeat (halves * len) @(negedge clk);
  endtask

  // sync, six bits LSB first, then two half-cells holding the last level
  task automatic send_frame(input logic [5:0] w, input int len, input bit corrupt);
    for (int i = 0; i < 3; i++) half(1'b1, len);
    for (int i = 0; i < 3; i++) half(1'b0, len);
    for (int i = 0; i < 6; i++) begin
      if (corrupt && i == 5) begin half(1'b1, len); half(1'b1, len); end
      else if (w[i])         begin half(1'b1, len); half(1'b0, len); end
      else                   begin half(1'b0, len); half(1'b1, len); end
    end
    hold(2, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    logic [5:0] keep;
    repeat (4) @(negedge clk);
    chk(gate == 0, "R8 reset gate", gate, 0);
    chk(locked == 0, "R8 reset lock", locked, 0);
    chk(frame_valid == 0, "R8 reset strobe", frame_valid, 0);
    rst_n = 1'b1;
    hold(30, HC);
    chk(locked == 0, "R8 idle line no lock", locked, 0);

    send_frame(6'h2D, HC, 1'b0);
    chk(locked == 0, "R6 one frame no lock", locked, 0);
    chk(gate == 0, "R8 gates low before lock", gate, 0);
    chk(strobes == 0, "R6 no strobe before lock", strobes, 0);

    send_frame(6'h12, HC, 1'b0);
    chk(locked == 1, "R6 lock after two", locked, 1);
    chk(strobes == 1, "R6 strobe on lock frame", strobes, 1);
    chk(last_gate == 6'h12, "R6 word on lock edge", last_gate, 6'h12);
    chk(gate == 6'h12, "R5 gate after lock", gate, 6'h12);

    // exhaustive sweep of the gate word; covers R2 bit order and R3 merged syncs
    for (int w = 0; w < 64; w++) begin
      s0 = strobes;
      send_frame(6'(w), HC, 1'b0);
      chk(gate == 6'(w), "R2 sweep word", gate, w);
      chk(strobes == s0 + 1, "R5 one strobe per frame", strobes, s0 + 1);
    end

    // slow sender: half-cell of OSR+1 samples
    for (int w = 0; w < 64; w += 9) begin
      send_frame(6'(w ^ 6'h15), HC + 1, 1'b0);
      chk(gate == 6'(w ^ 6'h15), "R1 slow sender", gate, w ^ 6'h15);
    end

    // long high idle merging into the sync high run
    half(1'b1, 5 * HC);
    send_frame(6'h01, HC, 1'b0);
    chk(gate == 6'h01, "R3 merged high run", gate, 1);

    // code error while locked
    keep = gate;
    s0 = strobes;
    send_frame(6'h3E, HC, 1'b1);
    chk(gate == keep, "R4 error keeps word", gate, keep);
    chk(strobes == s0, "R4 error no strobe", strobes, s0);
    chk(locked == 1, "R7 one bad keeps lock", locked, 1);
    send_frame(6'h2A, HC, 1'b0);
    chk(gate == 6'h2A, "R7 good resets bad count", gate, 6'h2A);
    send_frame(6'h11, HC, 1'b1);
    chk(locked == 1, "R7 bad count restarted", locked, 1);
    send_frame(6'h11, HC, 1'b1);
    chk(locked == 0, "R7 two errors unlock", locked, 0);
    chk(gate == 0, "R8 gates low after unlock", gate, 0);
    chk(strobe_unlocked == 0, "R5 no strobe while unlocked", strobe_unlocked, 0);

    send_frame(6'h33, HC, 1'b0);
    chk(locked == 0 && gate == 0, "R6 relock needs two", gate, 0);
    send_frame(6'h0C, HC, 1'b0);
    chk(locked == 1 && gate == 6'h0C, "R6 relock", gate, 6'h0C);

    // missing frames: line silent
    hold(40, HC);
    chk(locked == 0, "R7 missing frames unlock", locked, 0);
    chk(gate == 0, "R8 gates low on silence", gate, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule